// File: doc/BRIEF.md
# Read-to-Write Snoop Conversion Coherence Wrapper

This block sits between a shared snooping bus and a processor whose data cache knows only three line states: Modified, Exclusive and Invalid. It lets that processor work coherently next to peers whose caches also know a Shared state. The wrapper never lets a line become shared. Every read that another master puts on the bus reaches the local processor's snoop port as a write. The local copy is therefore dropped: a clean line is invalidated at once. A dirty line makes the wrapper raise a registered retry toward the bus, write the line back, and then invalidate it. The requester then repeats its read and becomes the only holder, in the Exclusive state.

The wrapper passes the processor's own outgoing requests to the bus unchanged. The only exception is while a write-back is pending: the write-back then owns the bus request lines and the local side is held off. The wrapper also keeps a cycle-level behavioural model of every line's state, which can be read through a query port. Commands use a 2-bit code on every command port: 0 read, 1 write, 2 kill, 3 write-back. Line states use a 2-bit code: 0 Invalid, 1 Exclusive, 2 Modified.

Top module: `coh_rtw_wrapper`

## Requirements
- R1: After a clock edge with `rst_n` low, every line reads Invalid (0) on `q_state`, `snp_retry` is 0 and `lcl_ready` is 1.
- R2: In the same cycle, `proc_snp_valid` equals `snp_valid` and `proc_snp_line` equals `snp_line`. `proc_snp_cmd` is write (1) when `snp_cmd` is read (0), and equals `snp_cmd` for write, kill and write-back.
- R3: A snooped read, write or kill that hits a line held Exclusive leaves that line Invalid after the next rising edge, and does not raise the retry.
- R4: A snooped read, write or kill that hits a Modified line, while no write-back is pending, raises `snp_retry` after the next rising edge. From then on the bus request shows write-back (3) for that line, and `lcl_ready` is 0.
- R5: `snp_retry` stays high until a cycle in which `bus_done` is 1 while the write-back is shown. After that edge, the retry is 0, `lcl_ready` is 1 and the written-back line is Invalid. A local request in that cycle does not complete.
- R6: A local read completed with `bus_done` (no write-back pending) takes an Invalid line to Exclusive. It leaves an Exclusive or Modified line unchanged.
- R7: A local write completed with `bus_done` (no write-back pending) leaves the line Modified, whatever state the line was in before.
- R8: With no write-back pending, `bus_valid`, `bus_cmd` and `bus_line` follow `lcl_valid`, `lcl_cmd` and `lcl_line` in the same cycle.
- R9: A snooped write-back, or any snoop of an Invalid line, changes no line state and does not raise the retry.
- R10: With two wrappers on one bus, replaying the following sequence never leaves both holding the same line valid: P2 reads, P1 reads, P1 writes, P2 reads (retried, P1 writes back, P2 reads again).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | Another master's address phase is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_line | input | LINE_W | Snooped line index |
| proc_snp_valid | output | 1 | Snoop presented to the local processor |
| proc_snp_cmd | output | 2 | Translated snoop command |
| proc_snp_line | output | LINE_W | Line index of the presented snoop |
| snp_retry | output | 1 | Registered retry toward the bus |
| lcl_valid | input | 1 | Local processor request |
| lcl_cmd | input | 2 | Local request command (read or write) |
| lcl_line | input | LINE_W | Local request line index |
| lcl_ready | output | 1 | Local request may use the bus |
| bus_valid | output | 1 | Bus request from this wrapper |
| bus_cmd | output | 2 | Bus request command |
| bus_line | output | LINE_W | Bus request line index |
| bus_done | input | 1 | This wrapper's address phase completed without retry |
| q_line | input | LINE_W | Line index to query |
| q_state | output | 2 | State code of the queried line |

## Verification
The translated snoop, the bus request mux and the ready flag are combinational, so they are due in the same cycle as the stimulus. Line states and the retry flag change on the rising edge after the stimulus cycle. Inputs change on the falling edge. The bench's reference model advances on each rising edge. A monitor compares all outputs 1 ns after every falling edge, which is after the registered results have settled and before the next edge. It then walks `q_line` across all lines in half-nanosecond steps, so every line state of both wrappers is checked in every cycle before the next rising edge.

// File: rtl/coh_rtw_pkg.sv
// Shared command and line-state codes for the read-to-write coherence wrapper.
// Assumes a 2-bit command field and a 2-bit line-state field on all ports.
package coh_rtw_pkg;
    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_WR   = 2'd1,
        CMD_KILL = 2'd2,
        CMD_WB   = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_E = 2'd1,
        LN_M = 2'd2
    } line_st_e;
endpackage

// File: rtl/coh_snoop_xlate.sv
// Snoop command translator: turns a snooped read into a write so the local
// cache gives the line up; every other command passes unchanged.
// Assumes the bus shows only other masters' address phases on the snoop inputs.
module coh_snoop_xlate
    import coh_rtw_pkg::*;
(
    input  logic     snp_valid,
    input  bus_cmd_e snp_cmd,
    output bus_cmd_e fwd_cmd,
    output logic     inval
);
    // Translate and flag snoops that must remove the local copy.
    always_comb begin
        fwd_cmd = (snp_cmd == CMD_RD) ? CMD_WR : snp_cmd;
        inval   = snp_valid && (snp_cmd != CMD_WB);
    end
endmodule

// File: rtl/coh_line_states.sv
// Behavioural per-line state model (Invalid / Exclusive / Modified).
// Assumes a local completion, a write-back completion and a snoop never target
// the same line in one cycle, as on a single shared bus.
module coh_line_states
    import coh_rtw_pkg::*;
#(
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              lcl_done,
    input  bus_cmd_e          lcl_cmd,
    input  logic [LINE_W-1:0] lcl_line,
    input  logic              wb_fire,
    input  logic [LINE_W-1:0] wb_line,
    input  logic [LINE_W-1:0] q_line,
    output line_st_e          q_state,
    output logic              snp_hit_m
);
    localparam int NUM_LINES = 1 << LINE_W;

    line_st_e st [NUM_LINES];

    // Advance line states on write-back, local completion and snoop invalidation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) st[i] <= LN_I;
        end else begin
            if (wb_fire) begin
                st[wb_line] <= LN_I;
            end else if (lcl_done) begin
                if (lcl_cmd == CMD_WR)
                    st[lcl_line] <= LN_M;
                else if (lcl_cmd == CMD_RD && st[lcl_line] == LN_I)
                    st[lcl_line] <= LN_E;
            end
            if (inval && st[snp_line] == LN_E)
                st[snp_line] <= LN_I;
        end
    end

    // Query port and dirty-hit detection.
    always_comb begin
        q_state   = st[q_line];
        snp_hit_m = inval && (st[snp_line] == LN_M);
    end

    // R3
    snp_e_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval && st[snp_line] == LN_E |=> st[$past(snp_line)] == LN_I);

    // R7
    lcl_wr_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_done && lcl_cmd == CMD_WR && !wb_fire && !(inval && snp_line == lcl_line)
        |=> st[$past(lcl_line)] == LN_M);

    // R5
    wb_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_fire |=> st[$past(wb_line)] == LN_I);
endmodule

// File: rtl/coh_retry_ctl.sv
// Retry and write-back controller: a registered flag raised on a snoop hit to a
// Modified line, held until the write-back address phase completes.
// Assumes one write-back outstanding at a time; further dirty hits meanwhile
// are covered by the retry that is already high.
module coh_retry_ctl #(
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_m,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              bus_done,
    output logic              wb_pend,
    output logic [LINE_W-1:0] wb_line,
    output logic              wb_fire
);
    // Capture a dirty hit, clear once the write-back is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_pend <= 1'b0;
            wb_line <= '0;
        end else if (wb_pend && bus_done) begin
            wb_pend <= 1'b0;
        end else if (!wb_pend && hit_m) begin
            wb_pend <= 1'b1;
            wb_line <= snp_line;
        end
    end

    // Write-back completes when the bus accepts it.
    always_comb wb_fire = wb_pend && bus_done;

    // R4
    retry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_m && !wb_pend |=> wb_pend && wb_line == $past(snp_line));

    // R5
    retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pend && !bus_done |=> wb_pend && $stable(wb_line));

    // R5
    retry_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_pend && bus_done |=> !wb_pend);
endmodule

// File: rtl/coh_rtw_wrapper.sv
// Coherence wrapper for a three-state (M/E/I) cache on a snooping bus.
// Snooped reads reach the processor as writes, so no line is ever shared.
// Dirty hits raise a registered retry until the line is written back.
// Assumes bus_done reports a completed, non-retried address phase of this wrapper.
module coh_rtw_wrapper
    import coh_rtw_pkg::*;
#(
    parameter int LINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [LINE_W-1:0] snp_line,
    output logic              proc_snp_valid,
    output logic [1:0]        proc_snp_cmd,
    output logic [LINE_W-1:0] proc_snp_line,
    output logic              snp_retry,
    input  logic              lcl_valid,
    input  logic [1:0]        lcl_cmd,
    input  logic [LINE_W-1:0] lcl_line,
    output logic              lcl_ready,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [LINE_W-1:0] bus_line,
    input  logic              bus_done,
    input  logic [LINE_W-1:0] q_line,
    output logic [1:0]        q_state
);
    bus_cmd_e          fwd_cmd;
    logic              inval;
    logic              hit_m;
    logic              wb_pend;
    logic              wb_fire;
    logic [LINE_W-1:0] wb_line;
    logic              lcl_done;
    line_st_e          q_st;

    coh_snoop_xlate u_xlate (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_e'(snp_cmd)),
        .fwd_cmd   (fwd_cmd),
        .inval     (inval)
    );

    coh_line_states #(.LINE_W(LINE_W)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .inval     (inval),
        .snp_line  (snp_line),
        .lcl_done  (lcl_done),
        .lcl_cmd   (bus_cmd_e'(lcl_cmd)),
        .lcl_line  (lcl_line),
        .wb_fire   (wb_fire),
        .wb_line   (wb_line),
        .q_line    (q_line),
        .q_state   (q_st),
        .snp_hit_m (hit_m)
    );

    coh_retry_ctl #(.LINE_W(LINE_W)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_m    (hit_m),
        .snp_line (snp_line),
        .bus_done (bus_done),
        .wb_pend  (wb_pend),
        .wb_line  (wb_line),
        .wb_fire  (wb_fire)
    );

    // Processor snoop port, bus request mux and local handshake.
    always_comb begin
        proc_snp_valid = snp_valid;
        proc_snp_cmd   = fwd_cmd;
        proc_snp_line  = snp_line;
        snp_retry      = wb_pend;
        lcl_ready      = !wb_pend;
        bus_valid      = wb_pend || lcl_valid;
        bus_cmd        = wb_pend ? CMD_WB : lcl_cmd;
        bus_line       = wb_pend ? wb_line : lcl_line;
        lcl_done       = lcl_valid && bus_done && !wb_pend;
        q_state        = q_st;
    end
endmodule

// File: tb/coh_rtw_wrapper_tb_top.sv
`timescale 1ns/100ps
module coh_rtw_wrapper_tb_top;
    localparam int LW = 2;
    localparam int NL = 1 << LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          sv [2];
    logic [1:0]    sc [2];
    logic [LW-1:0] sl [2];
    logic          lv [2];
    logic [1:0]    lc [2];
    logic [LW-1:0] ll [2];
    logic          bd [2];
    logic [LW-1:0] q_line;
    logic          psv [2];
    logic [1:0]    psc [2];
    logic [LW-1:0] psl [2];
    logic          rty [2];
    logic          rdy [2];
    logic          bv [2];
    logic [1:0]    bc [2];
    logic [LW-1:0] bl [2];
    logic [1:0]    qs [2];

    int tests = 0;
    int fails = 0;
    bit armed = 1'b0;
    int est [2][NL];
    int epend [2];
    int epl [2];

    coh_rtw_wrapper #(.LINE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(sv[0]), .snp_cmd(sc[0]), .snp_line(sl[0]),
        .proc_snp_valid(psv[0]), .proc_snp_cmd(psc[0]), .proc_snp_line(psl[0]),
        .snp_retry(rty[0]),
        .lcl_valid(lv[0]), .lcl_cmd(lc[0]), .lcl_line(ll[0]), .lcl_ready(rdy[0]),
        .bus_valid(bv[0]), .bus_cmd(bc[0]), .bus_line(bl[0]), .bus_done(bd[0]),
        .q_line(q_line), .q_state(qs[0])
    );

    coh_rtw_wrapper #(.LINE_W(LW)) peer_i (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(sv[1]), .snp_cmd(sc[1]), .snp_line(sl[1]),
        .proc_snp_valid(psv[1]), .proc_snp_cmd(psc[1]), .proc_snp_line(psl[1]),
        .snp_retry(rty[1]),
        .lcl_valid(lv[1]), .lcl_cmd(lc[1]), .lcl_line(ll[1]), .lcl_ready(rdy[1]),
        .bus_valid(bv[1]), .bus_cmd(bc[1]), .bus_line(bl[1]), .bus_done(bd[1]),
        .q_line(q_line), .q_state(qs[1])
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: advances both wrappers' expected state on each rising edge.
    always @(posedge clk) begin
        int o_snp;
        int o_pend;
        if (!rst_n) begin
            for (int m = 0; m < 2; m++) begin
                for (int l = 0; l < NL; l++) est[m][l] = 0;
                epend[m] = 0;
                epl[m] = 0;
            end
            armed = 1'b1;
        end else begin
            for (int m = 0; m < 2; m++) begin
                o_snp  = est[m][sl[m]];
                o_pend = epend[m];
                if (bd[m] && o_pend != 0) begin
                    est[m][epl[m]] = 0;
                    epend[m] = 0;
                end else if (bd[m] && lv[m]) begin
                    if (lc[m] == 2'd1) est[m][ll[m]] = 2;
                    else if (lc[m] == 2'd0 && est[m][ll[m]] == 0) est[m][ll[m]] = 1;
                end
                if (sv[m] && sc[m] != 2'd3) begin
                    if (o_snp == 1) est[m][sl[m]] = 0;
                    else if (o_snp == 2 && o_pend == 0) begin
                        epend[m] = 1;
                        epl[m] = int'(sl[m]);
                    end
                end
            end
        end
    end

    // Monitor: compares every output and every line state once per cycle.
    always @(negedge clk) begin
        int e;
        #1;
        if (armed) begin
            for (int m = 0; m < 2; m++) begin
                chk(psv[m] == sv[m], "R2 snoop valid", int'(psv[m]), int'(sv[m]));
                e = (sc[m] == 2'd0) ? 1 : int'(sc[m]);
                chk(int'(psc[m]) == e, "R2 snoop cmd", int'(psc[m]), e);
                chk(psl[m] == sl[m], "R2 snoop line", int'(psl[m]), int'(sl[m]));
                chk(int'(rty[m]) == epend[m], "R4 retry", int'(rty[m]), epend[m]);
                chk(int'(rdy[m]) == 1 - epend[m], "R5 lcl_ready", int'(rdy[m]), 1 - epend[m]);
                e = (epend[m] != 0 || lv[m]) ? 1 : 0;
                chk(int'(bv[m]) == e, "R8 bus_valid", int'(bv[m]), e);
                if (bv[m]) begin
                    e = (epend[m] != 0) ? 3 : int'(lc[m]);
                    chk(int'(bc[m]) == e, "R8 bus_cmd", int'(bc[m]), e);
                    e = (epend[m] != 0) ? epl[m] : int'(ll[m]);
                    chk(int'(bl[m]) == e, "R8 bus_line", int'(bl[m]), e);
                end
            end
            for (int l = 0; l < NL; l++) begin
                q_line = LW'(l);
                #0.5;
                for (int m = 0; m < 2; m++)
                    chk(int'(qs[m]) == est[m][l], "R1 R3 R6 R7 R9 line state",
                        int'(qs[m]), est[m][l]);
                chk(!(qs[0] != 2'd0 && qs[1] != 2'd0), "R10 single valid holder",
                    int'(qs[0]) * 4 + int'(qs[1]), 0);
            end
        end
    end

    task automatic clear_in();
        for (int m = 0; m < 2; m++) begin
            sv[m] = 1'b0; sc[m] = 2'd0; sl[m] = '0;
            lv[m] = 1'b0; lc[m] = 2'd0; ll[m] = '0; bd[m] = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        clear_in();
        repeat (n) @(negedge clk);
    endtask

    // Master m issues a request; the other wrapper snoops it in the same cycle.
    task automatic op(input int m, input logic [1:0] c, input int line, input bit done);
        clear_in();
        lv[m] = 1'b1; lc[m] = c; ll[m] = LW'(line); bd[m] = done;
        sv[1-m] = 1'b1; sc[1-m] = c; sl[1-m] = LW'(line);
        @(negedge clk);
        clear_in();
    endtask

    // Wrapper m sees a snoop with no local activity.
    task automatic snp(input int m, input logic [1:0] c, input int line);
        clear_in();
        sv[m] = 1'b1; sc[m] = c; sl[m] = LW'(line);
        @(negedge clk);
        clear_in();
    endtask

    // Wrapper m's write-back is accepted; the peer snoops it.
    task automatic wb(input int m, input int line, input bit with_lcl);
        clear_in();
        bd[m] = 1'b1;
        if (with_lcl) begin lv[m] = 1'b1; lc[m] = 2'd0; ll[m] = '0; end
        sv[1-m] = 1'b1; sc[1-m] = 2'd3; sl[1-m] = LW'(line);
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        q_line = '0;
        clear_in();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rty[0] == 1'b0 && rty[1] == 1'b0, "R1 retry after reset", int'(rty[0]), 0);
        chk(rdy[0] == 1'b1 && rdy[1] == 1'b1, "R1 ready after reset", int'(rdy[0]), 1);
        rst_n = 1'b1;
        idle(1);
        // R10: four-step scenario on line 1 (P1 = dut_i, P2 = peer_i)
        op(1, 2'd0, 1, 1'b1);
        op(0, 2'd0, 1, 1'b1);
        op(0, 2'd1, 1, 1'b1);
        op(1, 2'd0, 1, 1'b0);
        idle(2);
        op(1, 2'd0, 1, 1'b0);
        clear_in();
        lv[0] = 1'b1; lc[0] = 2'd0; ll[0] = 2'd2;
        @(negedge clk);
        wb(0, 1, 1'b0);
        idle(1);
        op(1, 2'd0, 1, 1'b1);
        // R7 R9: write from Invalid, peer snoop of Invalid line
        op(0, 2'd1, 2, 1'b1);
        // R6: read hit on Modified keeps Modified
        op(0, 2'd0, 2, 1'b1);
        // R9: snooped write-back changes nothing
        snp(0, 2'd3, 2);
        // R3: kill and write on Exclusive lines
        snp(1, 2'd2, 1);
        op(1, 2'd0, 3, 1'b1);
        snp(1, 2'd1, 3);
        // R4 R5: kill on Modified, write-back with concurrent local read
        snp(0, 2'd2, 2);
        idle(1);
        wb(0, 2, 1'b1);
        idle(1);
        op(0, 2'd0, 0, 1'b1);
        op(0, 2'd0, 0, 1'b1);
        idle(3);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule